// File: doc/BRIEF.md
# Clock-Compensating Elastic Buffer with Skip Symbol Steering

This block bridges a symbol stream from a recovered receive clock into a local read clock whose frequency differs by a small amount. One symbol enters on every write clock edge and one symbol leaves on every read clock edge. Each symbol is a 9-bit value: bit 8 is the control flag and bits 7:0 are the data byte. Each side sees the other side's counter as a Gray code passed through two flops. From it, each side computes its own view of how many symbols the buffer holds.

The block keeps that occupancy near the midpoint of the buffer, half of its depth. It only ever changes the number of skip symbols to do so. When the write clock runs fast, the write side drops an incoming skip symbol instead of storing it. When the write clock runs slow, the read side emits a skip symbol twice. Up to three skip slots can be programmed. Each slot has a primary word and an alternate word, each with its own enable. Two flags report an occupancy beyond programmable limits: overflow on the write side and underflow on the read side.

Each side has a small state machine with two states. The write side has WR_PASS, in which a removal may occur, and WR_SETTLE, which is entered on a removal, stays for SETTLE cycles and then returns to WR_PASS. The read side has RD_PASS, in which an insertion may occur, and RD_SETTLE, which is entered on an insertion, stays for SETTLE cycles and then returns to RD_PASS. The settle window lets the synchronised counter catch up before the next correction is made.

Top module: `elastic_skip_buffer`

## Requirements
- R1: After reset, every buffer entry holds the filler symbol 9'h1BC, the write counter leads the read counter by DEPTH/2, rd_sym shows the filler, and overflow, underflow, skip_added and skip_removed are all low.
- R2: When both clocks run at the same rate, no symbol is inserted and none is removed.
- R3: When the write clock is faster, incoming skip symbols are dropped while the write-side occupancy exceeds DEPTH/2+HYST. Each drop gives a one-cycle skip_removed pulse in the write domain.
- R4: When the write clock is slower, a skip symbol at the read head is emitted twice while the read-side occupancy is below DEPTH/2-HYST. The skip_added pulse is high in the read cycle of the first emission, and that symbol is a skip.
- R5: Every non-skip symbol leaves the buffer exactly once and in arrival order, whatever the occupancy does.
- R6: A symbol counts as a skip only if it equals skip_word[i] with skip_en[i] set, or equals alt_word[i] with both skip_en[i] and alt_en[i] set. All 9 bits are compared, including the control flag in bit 8.
- R7: overflow is a write-domain register that is high one cycle after the write-side occupancy exceeds full_thr, and low otherwise.
- R8: underflow is a read-domain register that is high one cycle after the read-side occupancy drops below empty_thr, and low otherwise.
- R9: After a removal (or an insertion), its side stays in its settle state for SETTLE cycles, so two skip_removed (or two skip_added) pulses are never adjacent.
- R10: Each counter crosses to the other domain as a registered Gray code that changes by at most one bit per source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| rd_clk | input | 1 | Local (read) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_sym | input | SW | Incoming symbol, {ctrl, data} |
| skip_word | input | NSKIP*SW | Primary skip word per slot |
| alt_word | input | NSKIP*SW | Alternate skip word per slot |
| skip_en | input | NSKIP | Slot enable |
| alt_en | input | NSKIP | Alternate word enable per slot |
| full_thr | input | PW | Overflow threshold on write-side occupancy |
| empty_thr | input | PW | Underflow threshold on read-side occupancy |
| rd_sym | output | SW | Outgoing symbol, {ctrl, data} |
| overflow | output | 1 | Write-side occupancy above full_thr |
| underflow | output | 1 | Read-side occupancy below empty_thr |
| skip_added | output | 1 | A skip is being repeated (read domain) |
| skip_removed | output | 1 | An incoming skip was dropped (write domain) |

## Verification
Skip removal and the overflow flag can both fire on the same write edge, because both are computed from the same write-side occupancy. To provoke this, the bench lowers full_thr to 20 while the write clock runs at 19 ns against a 20 ns read clock. Occupancy then climbs past the removal mark of 21 while overflow is already armed. The bench counts write cycles in which skip_removed and overflow are both high and requires at least one. Over the same period, the scoreboard must still receive every non-skip symbol in order, so the flag can have no effect on which symbol is dropped.

// File: rtl/eb_pkg.sv
package eb_pkg;

    typedef enum logic { WR_PASS, WR_SETTLE } wr_state_e;
    typedef enum logic { RD_PASS, RD_SETTLE } rd_state_e;

    // Gray conversion on a fixed 16-bit carrier; callers truncate.
    function automatic logic [15:0] to_gray(input logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [15:0] from_gray(input logic [15:0] g);
        logic [15:0] b;
        b[15] = g[15];
        for (int i = 14; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/eb_skip_match.sv
module eb_skip_match #(
    parameter int SW    = 9,
    parameter int NSKIP = 3
) (
    input  logic [SW-1:0]             sym,
    input  logic [NSKIP-1:0][SW-1:0]  skip_word,
    input  logic [NSKIP-1:0][SW-1:0]  alt_word,
    input  logic [NSKIP-1:0]          skip_en,
    input  logic [NSKIP-1:0]          alt_en,
    output logic                      hit
);
    logic [NSKIP-1:0] slot_hit;

    for (genvar i = 0; i < NSKIP; i++) begin : g_slot
        assign slot_hit[i] = skip_en[i] &
                             ((sym == skip_word[i]) | (alt_en[i] & (sym == alt_word[i])));
    end

    assign hit = |slot_hit;
endmodule

// File: rtl/eb_gray_sync.sv
module eb_gray_sync #(
    parameter int          W       = 6,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= W'(RST_VAL);
            q      <= W'(RST_VAL);
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/eb_wr_ctrl.sv
module eb_wr_ctrl
    import eb_pkg::*;
#(
    parameter int          SW     = 9,
    parameter int          NSKIP  = 3,
    parameter int          DEPTH  = 32,
    parameter int          HYST   = 5,
    parameter int          SETTLE = 4,
    parameter int unsigned FILL   = 'h1BC,
    localparam int         AW     = $clog2(DEPTH),
    localparam int         PW     = AW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SW-1:0]             in_sym,
    input  logic [NSKIP-1:0][SW-1:0]  skip_word,
    input  logic [NSKIP-1:0][SW-1:0]  alt_word,
    input  logic [NSKIP-1:0]          skip_en,
    input  logic [NSKIP-1:0]          alt_en,
    input  logic [PW-1:0]             rgray_s,
    input  logic [PW-1:0]             full_thr,
    output logic [DEPTH-1:0][SW-1:0]  mem,
    output logic [PW-1:0]             wgray,
    output logic                      overflow,
    output logic                      skip_removed
);
    localparam int          MID      = DEPTH / 2;
    localparam int unsigned MID_GRAY = MID ^ (MID >> 1);
    localparam int          CW       = $clog2(SETTLE + 1);
    localparam logic [PW-1:0] HI_MARK = PW'(MID + HYST);

    wr_state_e     st, st_nxt;
    logic [CW-1:0] settle_cnt;
    logic [PW-1:0] wptr, wptr_inc, rbin, occ;
    logic          in_is_skip, drop;

    eb_skip_match #(.SW(SW), .NSKIP(NSKIP)) u_match (
        .sym(in_sym), .skip_word(skip_word), .alt_word(alt_word),
        .skip_en(skip_en), .alt_en(alt_en), .hit(in_is_skip)
    );

    assign rbin     = PW'(from_gray(16'(rgray_s)));
    assign occ      = wptr - rbin;
    assign wptr_inc = wptr + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= WR_PASS;
            settle_cnt <= '0;
        end else begin
            st         <= st_nxt;
            settle_cnt <= (st == WR_SETTLE) ? settle_cnt + 1'b1 : '0;
        end
    end

    // next state and decision
    always_comb begin
        st_nxt = st;
        drop   = 1'b0;
        unique case (st)
            WR_PASS: begin
                if (in_is_skip && (occ > HI_MARK)) begin
                    drop   = 1'b1;
                    st_nxt = WR_SETTLE;
                end
            end
            WR_SETTLE: begin
                if (settle_cnt == CW'(SETTLE - 1)) st_nxt = WR_PASS;
            end
        endcase
    end

    // storage, pointer and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= SW'(FILL);
            wptr         <= PW'(MID);
            wgray        <= PW'(MID_GRAY);
            overflow     <= 1'b0;
            skip_removed <= 1'b0;
        end else begin
            skip_removed <= drop;
            overflow     <= (occ > full_thr);
            if (!drop) begin
                mem[wptr[AW-1:0]] <= in_sym;
                wptr              <= wptr_inc;
                wgray             <= PW'(to_gray(16'(wptr_inc)));
            end
        end
    end

    // R10
    wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
    // R9
    removal_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_removed |=> !skip_removed);
    // R3
    removal_on_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_removed |-> $past(in_is_skip));
endmodule

// File: rtl/eb_rd_ctrl.sv
module eb_rd_ctrl
    import eb_pkg::*;
#(
    parameter int          SW     = 9,
    parameter int          NSKIP  = 3,
    parameter int          DEPTH  = 32,
    parameter int          HYST   = 5,
    parameter int          SETTLE = 4,
    parameter int unsigned FILL   = 'h1BC,
    localparam int         AW     = $clog2(DEPTH),
    localparam int         PW     = AW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DEPTH-1:0][SW-1:0]  mem,
    input  logic [NSKIP-1:0][SW-1:0]  skip_word,
    input  logic [NSKIP-1:0][SW-1:0]  alt_word,
    input  logic [NSKIP-1:0]          skip_en,
    input  logic [NSKIP-1:0]          alt_en,
    input  logic [PW-1:0]             wgray_s,
    input  logic [PW-1:0]             empty_thr,
    output logic [PW-1:0]             rgray,
    output logic [SW-1:0]             rd_sym,
    output logic                      underflow,
    output logic                      skip_added
);
    localparam int CW = $clog2(SETTLE + 1);
    localparam logic [PW-1:0] LO_MARK = PW'(DEPTH / 2 - HYST);

    rd_state_e     st, st_nxt;
    logic [CW-1:0] settle_cnt;
    logic [PW-1:0] rptr, rptr_inc, wbin, occ;
    logic [SW-1:0] head;
    logic          head_is_skip, out_is_skip, hold;

    assign head     = mem[rptr[AW-1:0]];
    assign wbin     = PW'(from_gray(16'(wgray_s)));
    assign occ      = wbin - rptr;
    assign rptr_inc = rptr + 1'b1;

    eb_skip_match #(.SW(SW), .NSKIP(NSKIP)) u_head_match (
        .sym(head), .skip_word(skip_word), .alt_word(alt_word),
        .skip_en(skip_en), .alt_en(alt_en), .hit(head_is_skip)
    );

    // independent classifier on the registered output, used by the checks
    eb_skip_match #(.SW(SW), .NSKIP(NSKIP)) u_out_match (
        .sym(rd_sym), .skip_word(skip_word), .alt_word(alt_word),
        .skip_en(skip_en), .alt_en(alt_en), .hit(out_is_skip)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= RD_PASS;
            settle_cnt <= '0;
        end else begin
            st         <= st_nxt;
            settle_cnt <= (st == RD_SETTLE) ? settle_cnt + 1'b1 : '0;
        end
    end

    // next state and decision
    always_comb begin
        st_nxt = st;
        hold   = 1'b0;
        unique case (st)
            RD_PASS: begin
                if (head_is_skip && (occ < LO_MARK)) begin
                    hold   = 1'b1;
                    st_nxt = RD_SETTLE;
                end
            end
            RD_SETTLE: begin
                if (settle_cnt == CW'(SETTLE - 1)) st_nxt = RD_PASS;
            end
        endcase
    end

    // pointer and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr       <= '0;
            rgray      <= '0;
            rd_sym     <= SW'(FILL);
            underflow  <= 1'b0;
            skip_added <= 1'b0;
        end else begin
            rd_sym     <= head;
            skip_added <= hold;
            underflow  <= (occ < empty_thr);
            if (!hold) begin
                rptr  <= rptr_inc;
                rgray <= PW'(to_gray(16'(rptr_inc)));
            end
        end
    end

    // R10
    rgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
    // R4
    insert_is_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_added |-> out_is_skip);
    // R4
    insert_repeats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_added |=> (rd_sym == $past(rd_sym)));
    // R9
    insert_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_added |=> !skip_added);
endmodule

// File: rtl/elastic_skip_buffer.sv
module elastic_skip_buffer
    import eb_pkg::*;
#(
    parameter int          SW     = 9,
    parameter int          NSKIP  = 3,
    parameter int          DEPTH  = 32,
    parameter int          HYST   = 5,
    parameter int          SETTLE = 4,
    parameter int unsigned FILL   = 'h1BC,
    localparam int         AW     = $clog2(DEPTH),
    localparam int         PW     = AW + 1
) (
    input  logic                      wr_clk,
    input  logic                      rd_clk,
    input  logic                      rst_n,
    input  logic [SW-1:0]             wr_sym,
    input  logic [NSKIP-1:0][SW-1:0]  skip_word,
    input  logic [NSKIP-1:0][SW-1:0]  alt_word,
    input  logic [NSKIP-1:0]          skip_en,
    input  logic [NSKIP-1:0]          alt_en,
    input  logic [PW-1:0]             full_thr,
    input  logic [PW-1:0]             empty_thr,
    output logic [SW-1:0]             rd_sym,
    output logic                      overflow,
    output logic                      underflow,
    output logic                      skip_added,
    output logic                      skip_removed
);
    localparam int          MID      = DEPTH / 2;
    localparam int unsigned MID_GRAY = MID ^ (MID >> 1);

    logic [DEPTH-1:0][SW-1:0] mem;
    logic [PW-1:0] wgray, wgray_s, rgray, rgray_s;

    eb_wr_ctrl #(.SW(SW), .NSKIP(NSKIP), .DEPTH(DEPTH), .HYST(HYST),
                 .SETTLE(SETTLE), .FILL(FILL)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .in_sym(wr_sym),
        .skip_word(skip_word), .alt_word(alt_word), .skip_en(skip_en), .alt_en(alt_en),
        .rgray_s(rgray_s), .full_thr(full_thr), .mem(mem), .wgray(wgray),
        .overflow(overflow), .skip_removed(skip_removed)
    );

    eb_gray_sync #(.W(PW), .RST_VAL(MID_GRAY)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    eb_gray_sync #(.W(PW), .RST_VAL(0)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    eb_rd_ctrl #(.SW(SW), .NSKIP(NSKIP), .DEPTH(DEPTH), .HYST(HYST),
                 .SETTLE(SETTLE), .FILL(FILL)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .mem(mem),
        .skip_word(skip_word), .alt_word(alt_word), .skip_en(skip_en), .alt_en(alt_en),
        .wgray_s(wgray_s), .empty_thr(empty_thr), .rgray(rgray), .rd_sym(rd_sym),
        .underflow(underflow), .skip_added(skip_added)
    );
endmodule

// File: tb/test_elastic_skip_buffer.sv
`timescale 1ns/1ps
module test_elastic_skip_buffer;

    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic rst_n  = 1'b0;
    logic [8:0] wr_sym = 9'h1BC;
    logic [2:0][8:0] skip_word;
    logic [2:0][8:0] alt_word;
    logic [2:0] skip_en, alt_en;
    logic [5:0] full_thr  = 6'd28;
    logic [5:0] empty_thr = 6'd4;
    logic [8:0] rd_sym;
    logic overflow, underflow, skip_added, skip_removed;

    // R6 configuration: slot0 1BC with alternate 11C, slot1 1F7, slot2 1FD disabled
    assign skip_word = {9'h1FD, 9'h1F7, 9'h1BC};
    assign alt_word  = {9'h000, 9'h000, 9'h11C};
    assign skip_en   = 3'b011;
    assign alt_en    = 3'b001;

    elastic_skip_buffer i_elastic_skip_buffer (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_sym(wr_sym),
        .skip_word(skip_word), .alt_word(alt_word), .skip_en(skip_en), .alt_en(alt_en),
        .full_thr(full_thr), .empty_thr(empty_thr), .rd_sym(rd_sym),
        .overflow(overflow), .underflow(underflow),
        .skip_added(skip_added), .skip_removed(skip_removed)
    );

    realtime wr_half = 10.0;
    always #10 rd_clk = ~rd_clk;              // 50 MHz read clock
    initial begin
        #3;
        forever #(wr_half) wr_clk = ~wr_clk;
    end

    int checks = 0, errors = 0;
    bit done = 0, driving = 0, monitoring = 0;
    logic [8:0] exp_q[$];
    int n_added = 0, n_removed = 0, n_both = 0, n_data = 0;
    bit prev_added = 0, prev_removed = 0;
    int idx = 0;

    function automatic bit is_skip(input logic [8:0] s);
        return (s == 9'h1BC) || (s == 9'h11C) || (s == 9'h1F7);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one symbol per write edge, non-skips go to the scoreboard
    always @(negedge wr_clk) begin
        if (driving) begin
            logic [8:0] s;
            case (idx % 12)
                2:  s = 9'h1BC;
                5:  s = 9'h11C;
                8:  s = 9'h1F7;
                10: s = 9'h1FD;                 // disabled slot: plain data (R6)
                11: s = {1'b0, 8'hBC};          // ctrl clear: plain data (R6)
                default: s = {1'b0, idx[7:0]};  // includes 9'h000 vs unenabled alt (R6)
            endcase
            idx++;
            wr_sym <= s;
            if (!is_skip(s)) exp_q.push_back(s);
        end
        if (monitoring) begin
            if (skip_removed) n_removed++;
            if (skip_removed && overflow) n_both++;
            if (skip_removed && prev_removed)
                chk(0, "R9 adjacent removals", 1, 0);
            prev_removed = skip_removed;
        end
    end

    // monitor: pops and compares non-skip output symbols
    always @(negedge rd_clk) begin
        if (monitoring) begin
            if (skip_added) begin
                n_added++;
                chk(is_skip(rd_sym), "R4 inserted symbol is skip", int'(rd_sym), 'h1BC);
                if (prev_added) chk(0, "R9 adjacent insertions", 1, 0);
            end
            prev_added = skip_added;
            if (!is_skip(rd_sym)) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5 unexpected symbol", int'(rd_sym), -1);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    n_data++;
                    chk(rd_sym == e, "R5 R10 in-order data", int'(rd_sym), int'(e));
                end
            end
        end
    end

    task automatic rd_cycles(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    initial begin
        #61 rst_n = 1'b1;
        @(negedge rd_clk);
        @(negedge rd_clk);
        // R1 reset state
        chk(rd_sym == 9'h1BC, "R1 filler output", int'(rd_sym), 'h1BC);
        chk(!overflow, "R1 overflow low", int'(overflow), 0);
        chk(!underflow, "R1 underflow low", int'(underflow), 0);
        chk(!skip_added && !skip_removed, "R1 pulses low",
            int'({skip_added, skip_removed}), 0);
        driving = 1;
        monitoring = 1;

        // R2 equal rates
        rd_cycles(400);
        chk(n_added == 0, "R2 no insertion at equal rate", n_added, 0);
        chk(n_removed == 0, "R2 no removal at equal rate", n_removed, 0);

        // R7 / R8 thresholds at steady occupancy (about 16)
        full_thr = 6'd10;
        empty_thr = 6'd24;
        rd_cycles(10);
        chk(overflow, "R7 overflow above full_thr", int'(overflow), 1);
        chk(underflow, "R8 underflow below empty_thr", int'(underflow), 1);
        full_thr = 6'd28;
        empty_thr = 6'd4;
        rd_cycles(10);
        chk(!overflow, "R7 overflow clears", int'(overflow), 0);
        chk(!underflow, "R8 underflow clears", int'(underflow), 0);

        // R3 fast write, overflow armed at 20 to overlap with removals
        n_added = 0; n_removed = 0;
        full_thr = 6'd20;
        wr_half = 9.5;
        rd_cycles(3000);
        chk(n_removed > 0, "R3 skips removed when write is fast", n_removed, 1);
        chk(n_both > 0, "R7 overflow together with removal", n_both, 1);
        full_thr = 6'd28;

        // R4 slow write
        n_added = 0; n_removed = 0;
        wr_half = 10.5;
        rd_cycles(3000);
        chk(n_added > 0, "R4 skips inserted when write is slow", n_added, 1);
        chk(n_removed == 0, "R3 no removal when write is slow", n_removed, 0);
        chk(!underflow, "R8 no underflow under steering", int'(underflow), 0);

        // R5 nothing lost
        chk(n_data > 1000, "R5 data delivered", n_data, 1000);
        chk(exp_q.size() <= 32, "R5 backlog bounded by depth", exp_q.size(), 32);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule